// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes characters from the single half-duplex line of a smart card link. Each character has a low start bit, eight data bits sent least-significant bit first, and an even parity bit. The line is sampled in the middle of each elementary time unit (ETU). When the parity check fails, the block pulls the line low for one ETU during the guard time, which asks the sender to repeat the character.

The received byte goes into a data register together with three flags: receive-full, parity-error and overrun. One enable bit gates both interrupt requests: the receive-data request follows the receive-full flag, and the error request follows either error flag. A transfer engine can be started by a request that is raised only for clean characters. When the engine acknowledges, it clears the receive-full flag, but only if its disable input is low and its transfer count is nonzero. Software clears flags by writing zeros.

Top module: `sc_char_rx`

## Requirements
- R1: After a falling edge on an idle line, the start bit is checked half an ETU later. If the line is high again at that point, the event is dropped as a glitch and no character is received.
- R2: Eight data bits are sampled one ETU apart, the first one becoming bit 0 of the byte. The ninth bit is parity, and it must make the number of ones across the nine bits even.
- R3: A character that passes the parity check, arriving while receive-full is clear, writes its byte into `rx_data` and sets `rx_full`. `par_err` is left clear.
- R4: A character that fails the parity check sets `par_err` and leaves `rx_full` clear. Its byte is still written into `rx_data`.
- R5: After a parity error, `line_drive_low` is 1 for exactly one ETU, starting one ETU after the parity sample point (10.5 ETU after the start edge). At every other time it is 0.
- R6: A character that completes while `rx_full` is already 1 sets `ovr_err`, and `rx_data` keeps its previous value.
- R7: `rx_irq` equals `irq_en` AND `rx_full`. `err_irq` equals `irq_en` AND (`par_err` OR `ovr_err`).
- R8: `xfer_req` is 1 only when `irq_en` and `rx_full` are both 1 and neither error flag is set.
- R9: A pulse on `xfer_ack` clears `rx_full` only when `xfer_disable` is 0 and `xfer_count` is nonzero. In every other case `rx_full` stays set.
- R10: When `flag_wr` is high, each bit of `flag_wdata` that is 0 clears its flag and each bit that is 1 leaves its flag unchanged. Bit 0 is `rx_full`, bit 1 is `par_err` and bit 2 is `ovr_err`.
- R11: After reset, every flag, `rx_data`, every request output and `line_drive_low` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Serial line as seen at the pin |
| line_drive_low | output | 1 | 1 pulls the line low to signal an error |
| irq_en | input | 1 | Shared enable for both interrupt requests |
| flag_wr | input | 1 | Strobe for a software flag write |
| flag_wdata | input | 3 | Flag write data: 0 clears, 1 keeps (bit0 full, bit1 parity, bit2 overrun) |
| xfer_ack | input | 1 | Transfer engine has read the byte |
| xfer_disable | input | 1 | When 1, an engine read does not clear the full flag |
| xfer_count | input | 8 | Engine remaining transfer count |
| rx_data | output | 8 | Received data register |
| rx_full | output | 1 | Receive-full flag |
| par_err | output | 1 | Parity-error flag |
| ovr_err | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive-data interrupt request |
| err_irq | output | 1 | Error interrupt request |
| xfer_req | output | 1 | Transfer engine start request |

## Verification
The case that is hardest to reach from the ports is an overrun. A full, well-formed character has to arrive while the receive-full flag from an earlier character is still set. The stimulus therefore sends two good characters back to back with no acknowledge or flag write between them, then checks that the data register still holds the first byte. The error window on the line is timed from the bench's own start edge. It is sampled at whole-ETU marks that lie inside and outside the expected half-ETU-offset window, so synchroniser latency does not affect the result.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    localparam int DATA_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GUARD,
        ST_ERRSIG,
        ST_RECOVER
    } rx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 perr;
    } rx_char_t;

    typedef struct packed {
        logic ovr;
        logic perr;
        logic full;
    } rx_flags_t;

    // Even parity: error when data bits plus parity bit hold an odd number of ones.
    function automatic logic parity_bad(input logic [DATA_BITS-1:0] d, input logic p);
        return (^d) ^ p;
    endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sc_rx_sampler.sv
module sc_rx_sampler
    import sc_rx_pkg::*;
#(
    parameter int ETU_CYCLES = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_s,
    output logic     done,
    output rx_char_t result,
    output logic     drive_low
);
    localparam int CW   = $clog2(ETU_CYCLES);
    localparam int HALF = ETU_CYCLES / 2;

    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [2:0]           bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 err_q;
    logic                 etu_end;

    assign etu_end = (cnt == CW'(ETU_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            err_q   <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            cnt  <= cnt + 1'b1;
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (!line_s) state <= ST_START;
                end
                ST_START: begin
                    if (cnt == CW'(HALF - 1)) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= line_s ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (etu_end) begin
                        cnt   <= '0;
                        shreg <= {line_s, shreg[DATA_BITS-1:1]};
                        if (bit_idx == 3'd7) state <= ST_PARITY;
                        else                 bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (etu_end) begin
                        cnt         <= '0;
                        err_q       <= parity_bad(shreg, line_s);
                        result.data <= shreg;
                        result.perr <= parity_bad(shreg, line_s);
                        done        <= 1'b1;
                        state       <= ST_GUARD;
                    end
                end
                ST_GUARD: begin
                    if (etu_end) begin
                        cnt   <= '0;
                        state <= err_q ? ST_ERRSIG : ST_IDLE;
                    end
                end
                ST_ERRSIG: begin
                    if (etu_end) begin
                        cnt   <= '0;
                        state <= ST_RECOVER;
                    end
                end
                ST_RECOVER: begin
                    if (etu_end) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign drive_low = (state == ST_ERRSIG);

    AST_ERRSIG_AFTER_GUARD: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_low) |-> ($past(state) == ST_GUARD && err_q)) else $error("errsig"); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done"); // R2
endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags
    import sc_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done,
    input  rx_char_t             result,
    input  logic                 flag_wr,
    input  logic [2:0]           flag_wdata,
    input  logic                 xfer_ack,
    input  logic                 xfer_disable,
    input  logic [CNT_W-1:0]     xfer_count,
    output logic [DATA_BITS-1:0] data_q,
    output rx_flags_t            flags
);
    logic auto_clr;
    assign auto_clr = xfer_ack && !xfer_disable && (xfer_count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            flags  <= '0;
        end else begin
            if (flag_wr) begin
                if (!flag_wdata[0]) flags.full <= 1'b0;
                if (!flag_wdata[1]) flags.perr <= 1'b0;
                if (!flag_wdata[2]) flags.ovr  <= 1'b0;
            end
            if (auto_clr) flags.full <= 1'b0;
            if (done) begin
                if (flags.full) begin
                    flags.ovr  <= 1'b1;
                    flags.full <= 1'b1;
                end else begin
                    data_q <= result.data;
                    if (result.perr) flags.perr <= 1'b1;
                    else             flags.full <= 1'b1;
                end
            end
        end
    end

    AST_GOOD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        (done && !result.perr && !flags.full) |=> (flags.full && data_q == $past(result.data))) else $error("good"); // R3
    AST_PERR_BLOCKS_FULL: assert property (@(posedge clk) disable iff (rst)
        (done && result.perr && !flags.full) |=> (!flags.full && flags.perr && data_q == $past(result.data))) else $error("perr"); // R4
    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && flags.full) |=> (flags.ovr && $stable(data_q))) else $error("ovr"); // R6
    AST_ACK_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack && (xfer_disable || xfer_count == '0) && flags.full && !(flag_wr && !flag_wdata[0]))
        |=> flags.full) else $error("ack keep"); // R9
    AST_ACK_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack && !xfer_disable && xfer_count != '0 && !done) |=> !flags.full) else $error("ack clr"); // R9
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int ETU_CYCLES  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    output logic             line_drive_low,
    input  logic             irq_en,
    input  logic             flag_wr,
    input  logic [2:0]       flag_wdata,
    input  logic             xfer_ack,
    input  logic             xfer_disable,
    input  logic [CNT_W-1:0] xfer_count,
    output logic [7:0]       rx_data,
    output logic             rx_full,
    output logic             par_err,
    output logic             ovr_err,
    output logic             rx_irq,
    output logic             err_irq,
    output logic             xfer_req
);
    logic      line_s;
    logic      done;
    rx_char_t  result;
    rx_flags_t flags;

    sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(line_in), .q(line_s)
    );

    sc_rx_sampler #(.ETU_CYCLES(ETU_CYCLES)) u_sampler (
        .clk(clk), .rst(rst), .line_s(line_s),
        .done(done), .result(result), .drive_low(line_drive_low)
    );

    sc_rx_flags #(.CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst(rst), .done(done), .result(result),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .xfer_ack(xfer_ack), .xfer_disable(xfer_disable), .xfer_count(xfer_count),
        .data_q(rx_data), .flags(flags)
    );

    assign rx_full  = flags.full;
    assign par_err  = flags.perr;
    assign ovr_err  = flags.ovr;
    assign rx_irq   = irq_en && flags.full;
    assign err_irq  = irq_en && (flags.perr || flags.ovr);
    assign xfer_req = rx_irq && !flags.perr && !flags.ovr;

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> !err_irq) else $error("req"); // R8
endmodule

// File: tb/sc_char_rx_bench.sv
`timescale 1ns/1ps
module sc_char_rx_bench;
    localparam int ETU = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_tx = 1'b1;
    logic       line_in;
    logic       line_drive_low;
    logic       irq_en = 1'b0;
    logic       flag_wr = 1'b0;
    logic [2:0] flag_wdata = 3'b111;
    logic       xfer_ack = 1'b0;
    logic       xfer_disable = 1'b0;
    logic [7:0] xfer_count = 8'd0;
    logic [7:0] rx_data;
    logic       rx_full, par_err, ovr_err, rx_irq, err_irq, xfer_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    assign line_in = line_tx & ~line_drive_low;

    sc_char_rx #(.ETU_CYCLES(ETU)) u_sc_char_rx (
        .clk(clk), .rst(rst), .line_in(line_in), .line_drive_low(line_drive_low),
        .irq_en(irq_en), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .xfer_ack(xfer_ack), .xfer_disable(xfer_disable), .xfer_count(xfer_count),
        .rx_data(rx_data), .rx_full(rx_full), .par_err(par_err), .ovr_err(ovr_err),
        .rx_irq(rx_irq), .err_irq(err_irq), .xfer_req(xfer_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_flags(input logic [2:0] v);
        flag_wr = 1'b1; flag_wdata = v;
        cyc(1);
        flag_wr = 1'b0; flag_wdata = 3'b111;
        cyc(1);
    endtask

    task automatic ack(input logic dis, input logic [7:0] cnt);
        xfer_disable = dis; xfer_count = cnt; xfer_ack = 1'b1;
        cyc(1);
        xfer_ack = 1'b0;
        cyc(1);
    endtask

    // Sends one character; checks the error window on the line (R5).
    task automatic send_char(input logic [7:0] b, input logic bad);
        line_tx = 1'b0;
        cyc(ETU);
        for (int i = 0; i < 8; i++) begin
            line_tx = b[i];
            cyc(ETU);
        end
        line_tx = (^b) ^ bad;
        cyc(ETU);
        line_tx = 1'b1;
        chk("R5 no drive at 10 ETU", line_drive_low, 1'b0);
        cyc(ETU);
        chk("R5 drive at 11 ETU", line_drive_low, bad);
        cyc(2 * ETU);
        chk("R5 released at 13 ETU", line_drive_low, 1'b0);
        cyc(ETU);
    endtask

    task automatic t_reset;
        chk("R11 rx_full", rx_full, 0);
        chk("R11 par_err", par_err, 0);
        chk("R11 ovr_err", ovr_err, 0);
        chk("R11 rx_data", rx_data, 0);
        chk("R11 irqs", {rx_irq, err_irq, xfer_req}, 0);
        chk("R11 drive", line_drive_low, 0);
    endtask

    task automatic t_glitch;
        line_tx = 1'b0;
        cyc(3);
        line_tx = 1'b1;
        cyc(12 * ETU);
        chk("R1 glitch no full", rx_full, 0);
        chk("R1 glitch no perr", par_err, 0);
        chk("R1 glitch no drive", line_drive_low, 0);
    endtask

    task automatic t_good;
        irq_en = 1'b0;
        send_char(8'hA6, 1'b0);
        chk("R3 full set", rx_full, 1);
        chk("R2 R3 data lsb first", rx_data, 8'hA6);
        chk("R3 no perr", par_err, 0);
        chk("R7 irq gated off", {rx_irq, err_irq}, 0);
        chk("R8 req gated off", xfer_req, 0);
        irq_en = 1'b1;
        cyc(1);
        chk("R7 rx_irq", rx_irq, 1);
        chk("R8 xfer_req", xfer_req, 1);
        wr_flags(3'b111);
        chk("R10 write ones keeps full", rx_full, 1);
        ack(1'b1, 8'd5);
        chk("R9 disable keeps full", rx_full, 1);
        ack(1'b0, 8'd0);
        chk("R9 zero count keeps full", rx_full, 1);
        ack(1'b0, 8'd3);
        chk("R9 ack clears full", rx_full, 0);
        chk("R7 rx_irq drops", rx_irq, 0);
    endtask

    task automatic t_parity;
        send_char(8'h3C, 1'b1);
        chk("R4 perr set", par_err, 1);
        chk("R4 full clear", rx_full, 0);
        chk("R4 data still loaded", rx_data, 8'h3C);
        chk("R7 err_irq", err_irq, 1);
        chk("R8 no req on error", xfer_req, 0);
        wr_flags(3'b101);
        chk("R10 write zero clears perr", par_err, 0);
        send_char(8'h01, 1'b0);
        chk("R2 odd data byte ok", {rx_full, par_err, rx_data}, {2'b10, 8'h01});
        wr_flags(3'b110);
        chk("R10 write zero clears full", rx_full, 0);
    endtask

    task automatic t_overrun;
        send_char(8'h55, 1'b0);
        send_char(8'hF0, 1'b0);
        chk("R6 ovr set", ovr_err, 1);
        chk("R6 data held", rx_data, 8'h55);
        chk("R6 full stays", rx_full, 1);
        chk("R7 err_irq on ovr", err_irq, 1);
        chk("R8 no req on ovr", xfer_req, 0);
        wr_flags(3'b011);
        chk("R10 ovr cleared", {ovr_err, rx_full}, 2'b01);
        wr_flags(3'b000);
        chk("R10 all clear", {ovr_err, rx_full, par_err}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(4);
        t_reset();
        t_glitch();
        t_good();
        t_parity();
        t_overrun();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule